// File: doc/BRIEF.md
# Serial Debug Port with Trap Control

This block connects an external debug tool to a processor core that is halted in debug mode. The tool sends frames one bit at a time on a data-in pin, and each bit is sampled on the rising edge of a shift clock that the tool owns. Each frame carries an instruction, a data word, or a trap-control word. On the same shift clock, the block sends a word back to the tool on a data-out pin. The core loaded that word earlier by writing a data pseudo-register.

The core sees the port as two pseudo-registers behind a single receive path. It fetches every debug-mode instruction by reading the instruction pseudo-register. It exchanges data by reading and writing the data pseudo-register. A request is handled only when the special-register attribute is asserted and the address matches one of the two pseudo-registers.

The request side is a valid/ready stream. A selected write always completes in the cycle it is presented. A selected read holds `req_ready` low until a complete frame has crossed from the shift-clock domain into the core clock domain, which stalls the core. The response is a one-cycle `rsp_valid` pulse with no back-pressure, because the core always takes it.

If the kind of frame received does not match what the core asked for, the response is flagged and a sequence-error pin tells the tool. Trap-control frames never reach the core. They load a 9-bit control register whose bits drive the trap enable, breakpoint and sync inputs of the core.

Top module: `dbg_serial_port`

## Requirements
- R1: A frame begins with the first shift-clock rising edge at which `din` is 1 while the port is idle. That start bit is followed by a mode bit, a control bit, and 32 payload bits sent MSB first, all sampled on rising edges of `sck`. The kind is decoded from mode/control as follows: 0/0 is an instruction, 0/1 is data, and mode 1 with either control value is trap-control.
- R2: A read at the instruction address (default 630) with `req_spr` high returns the pending frame's payload on `rsp_data`. `rsp_valid` is high for exactly the one cycle after the handshake.
- R3: A read at the data address (default 631) returns the pending frame's payload in the same way. Each received frame satisfies exactly one read.
- R4: While no frame is pending, a selected read sees `req_ready` low. The read completes once a frame has been received.
- R5: A read whose address kind differs from the pending frame's kind still consumes the frame, but it returns `rsp_err`=1 and sets `seq_err`. A read whose kind matches returns `rsp_err`=0 and clears `seq_err`.
- R6: A trap-control frame loads payload bits [5:0] onto `trap_en`, [7:6] onto `brk_req` and [8] onto `sync_req`. It leaves no frame pending for the core.
- R7: No read or write from the core changes `trap_en`, `brk_req` or `sync_req`.
- R8: A selected write at the data address completes in its own cycle (`req_ready`=1) and stores the word. During the next frame, `dout` presents that word MSB first, with each bit valid before the rising edge that samples the matching payload bit. `dout` is 0 while no frame is in progress.
- R9: A selected write at the instruction address completes but is discarded, so the stored outgoing word does not change.
- R10: A request with `req_spr` low, or with any other address, sees `req_ready` low, gets no response and leaves any pending frame in place.
- R11: After reset, the control outputs, `seq_err`, `rsp_valid` and `dout` are 0, and no frame is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| sck | input | 1 | Shift clock from the debug tool |
| din | input | 1 | Serial data from the tool |
| dout | output | 1 | Serial data to the tool |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Request accepted this cycle |
| req_spr | input | 1 | Special-register access attribute |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 10 | Special-register address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response strobe |
| rsp_data | output | 32 | Read response data |
| rsp_err | output | 1 | Response kind mismatch |
| seq_err | output | 1 | Sequence-error indication to the tool |
| trap_en | output | 6 | Trap enable signals to the core |
| brk_req | output | 2 | Breakpoint request signals to the core |
| sync_req | output | 1 | Sync signal to the core |

## Verification
The bench sends data frames to instruction reads and instruction frames to data reads. A design that ignores the address kind, or keeps `seq_err` set after a good read, shows up as a flag with the wrong value. A read held before any frame arrives must stay stalled; a design that completes it early returns a stale payload. Trap-control frames followed by core reads and writes catch a design that leaks trap words to the core or lets the core disturb the control outputs. Writes at the instruction address and requests without the attribute catch a design that decodes addresses too loosely, which would corrupt the outgoing word or consume a pending frame.

// File: rtl/dsp_pkg.sv
package dsp_pkg;

  typedef enum logic [1:0] {
    XFER_INSTR = 2'd0,
    XFER_DATA  = 2'd1,
    XFER_TRAP  = 2'd2
  } xfer_kind_e;

  // Field positions follow the payload: [8] sync, [7:6] breakpoints, [5:0] traps.
  typedef struct packed {
    logic       sync;
    logic [1:0] brk;
    logic [5:0] trap;
  } trap_ctl_t;

  localparam int TRAP_CTL_W = $bits(trap_ctl_t);

  function automatic xfer_kind_e decode_kind(input logic mode, input logic ctrl);
    if (mode) return XFER_TRAP;
    else if (ctrl) return XFER_DATA;
    else return XFER_INSTR;
  endfunction

endpackage

// File: rtl/dsp_serial_rx.sv
module dsp_serial_rx #(
  parameter int PW = 32
) (
  input  logic          sck,
  input  logic          rst_n,
  input  logic          din,
  input  logic [PW-1:0] tx_word,
  output logic          dout,
  output logic          frm_mode,
  output logic          frm_ctrl,
  output logic [PW-1:0] frm_payload,
  output logic          frm_toggle
);
  localparam int FRAME_LEN = PW + 2;
  localparam int CW        = $clog2(FRAME_LEN + 1);
  localparam logic [CW-1:0] C_IDLE = '0;
  localparam logic [CW-1:0] C_MODE = CW'(1);
  localparam logic [CW-1:0] C_CTRL = CW'(2);
  localparam logic [CW-1:0] C_LAST = CW'(FRAME_LEN);

  logic [CW-1:0] cnt;
  logic          mode_r, ctrl_r;
  logic [PW-1:0] rx_sr;
  logic [PW-1:0] tx_sr;

  always_ff @(posedge sck or negedge rst_n) begin
    if (!rst_n) begin
      cnt         <= C_IDLE;
      mode_r      <= 1'b0;
      ctrl_r      <= 1'b0;
      rx_sr       <= '0;
      tx_sr       <= '0;
      frm_mode    <= 1'b0;
      frm_ctrl    <= 1'b0;
      frm_payload <= '0;
      frm_toggle  <= 1'b0;
    end else if (cnt == C_IDLE) begin
      if (din) begin
        cnt   <= C_MODE;
        tx_sr <= tx_word;   // snapshot outgoing word at the start bit
      end
    end else if (cnt == C_MODE) begin
      mode_r <= din;
      cnt    <= C_CTRL;
    end else if (cnt == C_CTRL) begin
      ctrl_r <= din;
      cnt    <= cnt + CW'(1);
    end else begin
      rx_sr <= {rx_sr[PW-2:0], din};
      tx_sr <= {tx_sr[PW-2:0], 1'b0};
      if (cnt == C_LAST) begin
        frm_payload <= {rx_sr[PW-2:0], din};
        frm_mode    <= mode_r;
        frm_ctrl    <= ctrl_r;
        frm_toggle  <= ~frm_toggle;
        cnt         <= C_IDLE;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  assign dout = (cnt != C_IDLE) & tx_sr[PW-1];

endmodule

// File: rtl/dsp_toggle_sync.sv
module dsp_toggle_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tog_in,
  output logic pulse
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], tog_in};
  end

  assign pulse = chain[STAGES] ^ chain[STAGES-1];

endmodule

// File: rtl/dsp_trap_reg.sv
module dsp_trap_reg
  import dsp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  trap_ctl_t load_val,
  output trap_ctl_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= load_val;
  end
endmodule

// File: rtl/dsp_core_if.sv
module dsp_core_if
  import dsp_pkg::*;
#(
  parameter int            AW         = 10,
  parameter int            PW         = 32,
  parameter logic [AW-1:0] INSTR_ADDR = AW'(630),
  parameter logic [AW-1:0] DATA_ADDR  = AW'(631)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_spr,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [PW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [PW-1:0] rsp_data,
  output logic          rsp_err,
  output logic          seq_err,
  input  logic          frm_evt,
  input  logic          frm_mode,
  input  logic          frm_ctrl,
  input  logic [PW-1:0] frm_payload,
  output logic [PW-1:0] tx_word,
  output logic          trap_load,
  output trap_ctl_t     trap_val
);
  xfer_kind_e    in_kind, pend_kind, exp_kind;
  logic          pend;
  logic [PW-1:0] pend_data;
  logic          hit_i, hit_d, sel, rd_fire, wr_data;

  assign in_kind  = decode_kind(frm_mode, frm_ctrl);
  assign hit_i    = req_spr && (req_addr == INSTR_ADDR);
  assign hit_d    = req_spr && (req_addr == DATA_ADDR);
  assign sel      = req_valid && (hit_i || hit_d);
  assign req_ready = sel && (req_write || pend);
  assign rd_fire  = sel && !req_write && pend;
  assign wr_data  = sel && req_write && hit_d;
  assign exp_kind = hit_i ? XFER_INSTR : XFER_DATA;

  assign trap_load = frm_evt && (in_kind == XFER_TRAP);
  assign trap_val  = trap_ctl_t'(frm_payload[TRAP_CTL_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      pend_kind <= XFER_INSTR;
      pend_data <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_err   <= 1'b0;
      seq_err   <= 1'b0;
      tx_word   <= '0;
    end else begin
      rsp_valid <= rd_fire;
      if (rd_fire) begin
        rsp_data <= pend_data;
        rsp_err  <= (pend_kind != exp_kind);
        seq_err  <= (pend_kind != exp_kind);
      end
      if (frm_evt && (in_kind != XFER_TRAP)) begin
        pend      <= 1'b1;
        pend_kind <= in_kind;
        pend_data <= frm_payload;
      end else if (rd_fire) begin
        pend <= 1'b0;
      end
      if (wr_data) tx_word <= req_wdata;
    end
  end

endmodule

// File: rtl/dbg_serial_port.sv
module dbg_serial_port
  import dsp_pkg::*;
#(
  parameter int            AW          = 10,
  parameter int            PW          = 32,
  parameter int            SYNC_STAGES = 2,
  parameter logic [AW-1:0] INSTR_ADDR  = AW'(630),
  parameter logic [AW-1:0] DATA_ADDR   = AW'(631)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck,
  input  logic          din,
  output logic          dout,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_spr,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [PW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [PW-1:0] rsp_data,
  output logic          rsp_err,
  output logic          seq_err,
  output logic [5:0]    trap_en,
  output logic [1:0]    brk_req,
  output logic          sync_req
);
  logic          frm_mode, frm_ctrl, frm_toggle, frm_evt, trap_load;
  logic [PW-1:0] frm_payload, tx_word;
  trap_ctl_t     trap_val, trap_q;

  dsp_serial_rx #(.PW(PW)) u_rx (
    .sck(sck), .rst_n(rst_n), .din(din), .tx_word(tx_word), .dout(dout),
    .frm_mode(frm_mode), .frm_ctrl(frm_ctrl), .frm_payload(frm_payload),
    .frm_toggle(frm_toggle)
  );

  dsp_toggle_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .tog_in(frm_toggle), .pulse(frm_evt)
  );

  dsp_core_if #(.AW(AW), .PW(PW), .INSTR_ADDR(INSTR_ADDR), .DATA_ADDR(DATA_ADDR)) u_if (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_spr(req_spr),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err), .seq_err(seq_err),
    .frm_evt(frm_evt), .frm_mode(frm_mode), .frm_ctrl(frm_ctrl),
    .frm_payload(frm_payload), .tx_word(tx_word),
    .trap_load(trap_load), .trap_val(trap_val)
  );

  dsp_trap_reg u_trap (
    .clk(clk), .rst_n(rst_n), .load(trap_load), .load_val(trap_val), .q(trap_q)
  );

  assign trap_en  = trap_q.trap;
  assign brk_req  = trap_q.brk;
  assign sync_req = trap_q.sync;

endmodule

// File: rtl/dsp_port_checker.sv
module dsp_port_checker #(
  parameter int            AW        = 10,
  parameter logic [AW-1:0] DATA_ADDR = AW'(631)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_spr,
  input logic          req_write,
  input logic [AW-1:0] req_addr,
  input logic          rsp_valid,
  input logic          rsp_err,
  input logic          seq_err
);
  assert_write_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_spr && req_write && req_addr == DATA_ADDR) |-> req_ready);

  assert_rsp_follows_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready && !req_write));

  assert_seqerr_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(seq_err) |-> rsp_valid);

  assert_seqerr_tracks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (seq_err == rsp_err));

  assert_no_attr_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_spr) |-> !req_ready);
endmodule

bind dbg_serial_port dsp_port_checker #(.AW(AW), .DATA_ADDR(DATA_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_spr(req_spr), .req_write(req_write), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .seq_err(seq_err)
);

// File: tb/dbg_serial_port_bench.sv
`timescale 1ns/1ps
module dbg_serial_port_bench;
  localparam logic [9:0] IA = 10'd630;
  localparam logic [9:0] DA = 10'd631;
  // vector: {mode, ctrl, payload[31:0], read_at_instr, expected_err}
  localparam int NV = 6;
  localparam logic [35:0] VEC [NV] = '{
    {2'b00, 32'hDEADBEEF, 1'b1, 1'b0},
    {2'b01, 32'h12345678, 1'b0, 1'b0},
    {2'b01, 32'h0BADF00D, 1'b1, 1'b1},
    {2'b00, 32'hCAFE0001, 1'b1, 1'b0},
    {2'b00, 32'h00000000, 1'b0, 1'b1},
    {2'b01, 32'hFFFFFFFF, 1'b0, 1'b0}
  };

  logic clk = 0, rst_n = 0, sck = 0, din = 0;
  logic dout, req_valid = 0, req_ready, req_spr = 0, req_write = 0;
  logic [9:0] req_addr = '0;
  logic [31:0] req_wdata = '0, rsp_data;
  logic rsp_valid, rsp_err, seq_err, sync_req;
  logic [5:0] trap_en;
  logic [1:0] brk_req;
  int checks = 0, errors = 0;
  logic [31:0] cap;
  logic [31:0] rd_data;
  logic rd_err, rd_ok;

  always #2.5 clk = ~clk;

  dbg_serial_port u_dbg_serial_port (
    .clk(clk), .rst_n(rst_n), .sck(sck), .din(din), .dout(dout),
    .req_valid(req_valid), .req_ready(req_ready), .req_spr(req_spr),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err), .seq_err(seq_err),
    .trap_en(trap_en), .brk_req(brk_req), .sync_req(sync_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R1: start bit, mode, ctrl, payload MSB first; dout captured before each payload rise
  task automatic send_frame(input logic mode, input logic ctrl, input logic [31:0] pl);
    logic [34:0] bits;
    bits = {1'b1, mode, ctrl, pl};
    for (int i = 34; i >= 0; i--) begin
      din = bits[i];
      #5;
      if (i <= 31) cap[i] = dout;
      #15 sck = 1;
      #20 sck = 0;
    end
    din = 0;
    #20;
  endtask

  task automatic do_read(input logic [9:0] addr);
    int n;
    @(negedge clk);
    req_valid = 1; req_spr = 1; req_write = 0; req_addr = addr;
    #1;
    n = 0;
    while (!req_ready && n < 20000) begin @(negedge clk); #1; n++; end
    @(posedge clk);
    @(negedge clk);
    rd_ok = rsp_valid; rd_data = rsp_data; rd_err = rsp_err;
    req_valid = 0;
  endtask

  task automatic do_write(input logic [9:0] addr, input logic [31:0] d, input string req);
    @(negedge clk);
    req_valid = 1; req_spr = 1; req_write = 1; req_addr = addr; req_wdata = d;
    #1 chk(req, {31'd0, req_ready}, 32'd1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic hold_stalled(input logic spr, input logic [9:0] addr, input string req);
    logic seen_rdy, seen_rsp;
    seen_rdy = 0; seen_rsp = 0;
    @(negedge clk);
    req_valid = 1; req_spr = spr; req_write = 0; req_addr = addr;
    for (int k = 0; k < 12; k++) begin
      #1; seen_rdy |= req_ready; seen_rsp |= rsp_valid;
      @(negedge clk);
    end
    req_valid = 0;
    chk({req, " ready"}, {31'd0, seen_rdy}, 32'd0);
    chk({req, " rsp"}, {31'd0, seen_rsp}, 32'd0);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R11: reset state, checked before reset is released
    chk("R11 trap", {23'd0, sync_req, brk_req, trap_en}, 32'd0);
    chk("R11 seq_err", {31'd0, seq_err}, 32'd0);
    chk("R11 dout", {31'd0, dout}, 32'd0);
    chk("R11 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    rst_n = 1;
    // R11: no frame pending after reset
    hold_stalled(1'b1, IA, "R11 no pending");

    // Table walk: R1 R2 R3 R5
    for (int v = 0; v < NV; v++) begin
      send_frame(VEC[v][35], VEC[v][34], VEC[v][33:2]);
      do_read(VEC[v][1] ? IA : DA);
      chk("R2/R3 rsp_valid", {31'd0, rd_ok}, 32'd1);
      chk("R1 R2 R3 data", rd_data, VEC[v][33:2]);
      chk("R5 rsp_err", {31'd0, rd_err}, {31'd0, VEC[v][0]});
      chk("R5 seq_err pin", {31'd0, seq_err}, {31'd0, VEC[v][0]});
    end

    // R4: read stalls until a frame arrives
    @(negedge clk);
    req_valid = 1; req_spr = 1; req_write = 0; req_addr = DA;
    repeat (15) @(negedge clk);
    chk("R4 stall", {31'd0, req_ready}, 32'd0);
    send_frame(1'b0, 1'b1, 32'h600DCAFE);
    begin
      int n = 0;
      #1;
      while (!req_ready && n < 100) begin @(negedge clk); #1; n++; end
    end
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    chk("R4 late data", rsp_data, 32'h600DCAFE);

    // R6: trap frames
    send_frame(1'b1, 1'b0, 32'h000001A5);
    repeat (10) @(negedge clk);
    chk("R6 trap load a", {23'd0, sync_req, brk_req, trap_en}, 32'h1A5);
    send_frame(1'b1, 1'b1, 32'hFFFFFE4A);
    repeat (10) @(negedge clk);
    chk("R6 trap load b", {23'd0, sync_req, brk_req, trap_en}, 32'h04A);
    hold_stalled(1'b1, DA, "R6 no pending");

    // R7: core accesses leave control bits alone
    do_write(DA, 32'hFFFFFFFF, "R8 write ready");
    do_write(IA, 32'h000001FF, "R9 write ready");
    send_frame(1'b0, 1'b1, 32'h000001FF);
    do_read(DA);
    chk("R7 trap unchanged", {23'd0, sync_req, brk_req, trap_en}, 32'h04A);

    // R8: outgoing word on dout
    do_write(DA, 32'hA5C30F96, "R8 write ready");
    send_frame(1'b0, 1'b0, 32'h0);
    chk("R8 dout word", cap, 32'hA5C30F96);
    chk("R8 dout idle", {31'd0, dout}, 32'd0);
    do_read(IA);

    // R9: write at the instruction address is discarded
    do_write(DA, 32'h11111111, "R8 write ready");
    do_write(IA, 32'h22222222, "R9 write ready");
    send_frame(1'b0, 1'b0, 32'h0);
    chk("R9 dout word", cap, 32'h11111111);
    do_read(IA);

    // R10: unselected requests
    send_frame(1'b0, 1'b1, 32'h55AA55AA);
    repeat (10) @(negedge clk);
    hold_stalled(1'b0, DA, "R10 no attr");
    hold_stalled(1'b1, 10'h123, "R10 other addr");
    do_read(DA);
    chk("R10 pending kept", rd_data, 32'h55AA55AA);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule